// File: doc/BRIEF.md
# Double-Buffered Control Register Bank

This block holds the control registers of a device in two copies. The staging copy is written one byte at a time by a serial control port. The live copy drives a wide parallel bus into the rest of the chip. Ordinary writes change only the staging copy. The controller can therefore rewrite any number of locations, one after another, without the device seeing a half-finished configuration.

When the controller writes a 1 into bit 0 of a dedicated commit location, every staged byte is copied into the live copy on the same clock edge. The commit bit then clears itself. Reads return the staging copy, so pending values can be checked before they are committed. Bank locations include reserved ones, and they keep whatever is written to them. Addresses outside the bank accept writes and ignore them.

Top module: `sbr_bank`

## Requirements
- R1: After reset, both copies of location i (0 <= i < N_REGS) hold the default ((i*29) mod 256) XOR 0xA5. The live bus shows these values, and the commit location reads 0.
- R2: A write to bank address i < N_REGS changes the staging byte i from the next edge onward. It leaves active_o unchanged.
- R3: A write of data with bit 0 = 1 to COMMIT_ADDR sets the commit bit at that edge. On the following edge every live byte takes the staging value held just before that edge.
- R4: The commit bit reads back as 1 (rd_data_o = 0x01 at COMMIT_ADDR) during the one cycle after the commit write. It then returns to 0 unless the commit is written again.
- R5: Any number of staged bytes, up to the whole bank, become visible on active_o at the same edge.
- R6: A write to COMMIT_ADDR with bit 0 = 0 has no effect: no transfer occurs and the commit bit stays 0.
- R7: A write to an address that is >= N_REGS and not COMMIT_ADDR changes no stored byte. A read of such an address returns 0x00.
- R8: A bank write in the cycle in which the commit bit is 1 lands in the staging copy only. The transfer carries the older staging value, and the new byte reaches the live copy at the next commit.
- R9: active_o changes only on the edge that follows a cycle in which the commit bit is 1.
- R10: rd_data_o shows the staging byte at rd_addr_i combinationally. This includes values written but not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Staging byte or commit bit at rd_addr_i |
| active_o | output | N_REGS*8 | Live register bus; byte i at bits [8i+7:8i] |

## Verification
The hardest case to reach is a write that lands in the single cycle while the commit bit is pending. In that cycle the transfer and the staging write act on the same byte at the same edge. The stimulus writes a byte directly after the commit write and checks that the live copy keeps the older value until a second commit. Back-to-back commit writes and a full-bank rewrite followed by one commit are also driven. A per-cycle model compares the whole live bus and the read port on every clock.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef logic [7:0] byte_t;

  function automatic byte_t sbr_default(int unsigned idx);
    return byte_t'((idx * 29) % 256) ^ 8'hA5;
  endfunction
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned N_REGS = 64,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 10'h232
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit0_i,
  output logic [N_REGS-1:0] wr_sel_o,
  output logic              commit_req_o
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_sel
    assign wr_sel_o[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
  end

  assign commit_req_o = wr_en_i && (wr_addr_i == COMMIT_ADDR) && wr_bit0_i;
endmodule

// File: rtl/sbr_cell.sv
module sbr_cell
  import sbr_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  byte_t wdata_i,
  input  logic  xfer_i,
  output byte_t stage_o,
  output byte_t live_o
);
  localparam byte_t DEF = sbr_default(IDX);

  byte_t stage_q, live_q;

  // transfer samples the pre-edge staging value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= DEF;
      live_q  <= DEF;
    end else begin
      if (xfer_i) live_q <= stage_q;
      if (we_i)   stage_q <= wdata_i;
    end
  end

  assign stage_o = stage_q;
  assign live_o  = live_q;
endmodule

// File: rtl/sbr_commit_ctl.sv
module sbr_commit_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_req_i,
  output logic commit_o
);
  logic commit_q;

  // self-clearing: holds 1 for exactly one cycle per request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) commit_q <= 1'b0;
    else         commit_q <= commit_req_i;
  end

  assign commit_o = commit_q;
endmodule

// File: rtl/sbr_read_mux.sv
module sbr_read_mux #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned N_REGS = 64,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 10'h232
) (
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [N_REGS*8-1:0] stage_flat_i,
  input  logic                commit_i,
  output logic [7:0]          rd_data_o
);
  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < N_REGS; i++) begin
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = stage_flat_i[i*8 +: 8];
    end
    if (rd_addr_i == COMMIT_ADDR) rd_data_o = {7'b0, commit_i};
  end
endmodule

// File: rtl/sbr_bank.sv
module sbr_bank
  import sbr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned N_REGS = 64,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 10'h232
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [7:0]          wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [7:0]          rd_data_o,
  output logic [N_REGS*8-1:0] active_o
);
  localparam int unsigned BUS_W = N_REGS * 8;

  logic [N_REGS-1:0] wr_sel;
  logic              commit_req;
  logic              commit_q;
  logic [BUS_W-1:0]  stage_flat;

  sbr_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS), .COMMIT_ADDR(COMMIT_ADDR)) u_dec (
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_bit0_i   (wr_data_i[0]),
    .wr_sel_o    (wr_sel),
    .commit_req_o(commit_req)
  );

  sbr_commit_ctl u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_req_i(commit_req),
    .commit_o    (commit_q)
  );

  for (genvar g = 0; g < N_REGS; g++) begin : g_cell
    byte_t stage_b, live_b;
    sbr_cell #(.IDX(g)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_sel[g]),
      .wdata_i(wr_data_i),
      .xfer_i (commit_q),
      .stage_o(stage_b),
      .live_o (live_b)
    );
    assign stage_flat[g*8 +: 8] = stage_b;
    assign active_o[g*8 +: 8]   = live_b;
  end

  sbr_read_mux #(.ADDR_W(ADDR_W), .N_REGS(N_REGS), .COMMIT_ADDR(COMMIT_ADDR)) u_rd (
    .rd_addr_i   (rd_addr_i),
    .stage_flat_i(stage_flat),
    .commit_i    (commit_q),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/sbr_bank_chk.sv
module sbr_bank_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned N_REGS = 64,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 10'h232
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [7:0]          wr_data_i,
  input logic                commit_q,
  input logic [N_REGS*8-1:0] stage_flat,
  input logic [N_REGS*8-1:0] active_o
);
  logic hit_commit, hit_blank;
  assign hit_commit = wr_en_i && (wr_addr_i == COMMIT_ADDR);
  assign hit_blank  = wr_en_i && (wr_addr_i >= ADDR_W'(N_REGS)) && (wr_addr_i != COMMIT_ADDR);

  assert_commit_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_commit && wr_data_i[0]) |=> commit_q);

  assert_commit_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> (active_o == $past(stage_flat)));

  assert_self_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_q && !(hit_commit && wr_data_i[0])) |=> !commit_q);

  assert_zero_bit_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_commit && !wr_data_i[0]) |=> !commit_q);

  assert_blank_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_blank |=> $stable(stage_flat));

  assert_live_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_q |=> $stable(active_o));
endmodule

bind sbr_bank sbr_bank_chk #(
  .ADDR_W(ADDR_W), .N_REGS(N_REGS), .COMMIT_ADDR(COMMIT_ADDR)
) u_sbr_bank_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .commit_q  (commit_q),
  .stage_flat(stage_flat),
  .active_o  (active_o)
);

// File: tb/sbr_bank_bench.sv
`timescale 1ns/1ps
module sbr_bank_bench;
  localparam int ADDR_W = 10;
  localparam int N = 64;
  localparam logic [ADDR_W-1:0] CADDR = 10'h232;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [N*8-1:0] active_o;

  sbr_bank #(.ADDR_W(ADDR_W), .N_REGS(N), .COMMIT_ADDR(CADDR)) u_sbr_bank (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  // reference model
  int m_stage [N];
  int m_live  [N];
  bit m_commit;

  function automatic int def_val(int i);
    return ((i * 29) % 256) ^ 'hA5;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin m_stage[i] = def_val(i); m_live[i] = def_val(i); end
      m_commit = 0;
    end else begin
      if (m_commit) for (int i = 0; i < N; i++) m_live[i] = m_stage[i];
      if (wr_en_i && int'(wr_addr_i) < N) m_stage[int'(wr_addr_i)] = int'(wr_data_i);
      m_commit = wr_en_i && wr_addr_i == CADDR && wr_data_i[0];
    end
  end

  function automatic int exp_rd(int a);
    if (a < N) return m_stage[a];
    if (a == int'(CADDR)) return int'(m_commit);
    return 0;
  endfunction

  // compare every cycle, 1 ns after the driving edge
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      for (int i = 0; i < N; i++) begin
        checks++;
        if (int'(active_o[i*8 +: 8]) != m_live[i]) begin
          fails++;
          $display("FAIL %s live[%0d] actual=%02h expected=%02h", req, i, active_o[i*8 +: 8], m_live[i]);
        end
      end
      checks++;
      if (int'(rd_data_o) != exp_rd(int'(rd_addr_i))) begin
        fails++;
        $display("FAIL %s rd[%0h] actual=%02h expected=%02h", req, rd_addr_i, rd_data_o, exp_rd(int'(rd_addr_i)));
      end
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = ADDR_W'(a); wr_data_i = 8'(d); rd_addr_i = ADDR_W'(a);
  endtask

  task automatic rd(int a);
    @(negedge clk_i);
    wr_en_i = 0; rd_addr_i = ADDR_W'(a);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    req = "R1";
    rd(0); rd(17); rd(N-1); rd(int'(CADDR));
    req = "R2";
    wr(0, 'h3C); wr(5, 'hC3); wr(N-1, 'h01); rd(0); rd(5); rd(N-1);
    req = "R10";
    wr(9, 'h77); rd(9); rd(8);
    req = "R6";
    wr(int'(CADDR), 'hFE); rd(int'(CADDR)); rd(0);
    req = "R7";
    wr(N, 'hAA); wr(1023, 'h55); wr(int'(CADDR) + 1, 'h99); rd(N); rd(1023); rd(1);
    req = "R3";
    wr(int'(CADDR), 'h01);
    req = "R4";
    rd(int'(CADDR)); rd(int'(CADDR)); rd(int'(CADDR));
    req = "R9";
    wr(12, 'h5A); rd(12); rd(12);
    req = "R8";
    wr(int'(CADDR), 'h81); wr(12, 'hE7); rd(12); rd(12);
    wr(int'(CADDR), 'h01); rd(12); rd(12);
    req = "R5";
    for (int i = 0; i < N; i++) wr(i, (i * 7 + 3) & 'hFF);
    rd(0); rd(33);
    wr(int'(CADDR), 'h01); wr(int'(CADDR), 'h01); rd(int'(CADDR)); rd(int'(CADDR)); rd(2);
    req = "R8";
    wr(int'(CADDR), 'h01); wr(40, 'h11); wr(41, 'h22); rd(40); rd(41);
    wr(int'(CADDR), 'h03); rd(40); rd(int'(CADDR));
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule